// File: doc/BRIEF.md
# Counter-Match Limit Checker with Interlock

This block supervises the results of a ramp-type multi-channel converter. All channels share one rising step counter. Each channel has a data-valid flag, which the conversion sequencer sets once that channel's input has been crossed by the ramp. The checker has no magnitude comparators. It compares the running counter for equality against each channel's upper and lower limit on every step.

- An upper-limit hit that comes before the channel's data-valid flag means the measurement lies above the limit.
- A lower-limit hit that comes after the flag means the measurement lies below the limit.

Each kind of violation sets a sticky warning bit for that channel. A per-channel mask removes a channel from all downstream effects. The unmasked warnings are collapsed into a packet status flag and into two interlock outputs. One interlock stops the hybrid clocks and the other shuts down the front-end regulators. Each interlock has its own enable bit.

Top module: `lmc_limit_chk`

## Requirements
- R1: On a cycle with `step_en` high, if `ramp_cnt` equals a channel's upper limit and that channel's effective valid flag is clear, its `warn_hi` bit is 1 after the next rising clock edge.
- R2: On a cycle with `step_en` high, if `ramp_cnt` equals a channel's lower limit and that channel's effective valid flag is set, its `warn_lo` bit is 1 after the next rising clock edge.
- R3: A limit match sets nothing when `step_en` is low, or when the valid flag is in the opposite state to the one R1 or R2 needs.
- R4: Warning bits stay set until a clear or a reset. Neither `cycle_start` nor later non-matching steps clear them.
- R5: A high `clr_warn` clears every warning bit at the next edge. A channel that meets R1 or R2 in the same cycle ends up set.
- R6: While `cycle_start` is high, every channel's effective valid flag is treated as clear.
- R7: `pkt_flag` is registered. It equals the OR over all channels of (`warn_hi` | `warn_lo`) & ~`mask`, taken one cycle earlier. A masked channel never raises it.
- R8: `clk_disable` is the registered unmasked-warning OR ANDed with `clk_kill_en`. It is 0 whenever the enable was 0 in the previous cycle.
- R9: `reg_disable` is the registered unmasked-warning OR ANDed with `reg_kill_en`. It is independent of `clk_kill_en`.
- R10: If a channel's lower limit exceeds its upper limit, the channel may hold both `warn_hi` and `warn_lo` at once.
- R11: After reset every warning bit, `pkt_flag`, `clk_disable` and `reg_disable` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ramp_cnt | input | CNT_W | Shared ramp step counter |
| step_en | input | 1 | Counter step qualifier; limits are evaluated only on these cycles |
| cycle_start | input | 1 | First cycle of a new ramp; valid flags are treated as clear |
| valid | input | NUM_CH | Per-channel data-valid flags from the sequencer |
| hi_lim | input | NUM_CH*CNT_W | Upper limits, channel n at bits [n*CNT_W +: CNT_W] |
| lo_lim | input | NUM_CH*CNT_W | Lower limits, same packing as `hi_lim` |
| mask | input | NUM_CH | 1 removes a channel from the flag and both interlocks |
| clr_warn | input | 1 | Clear strobe for all warning bits |
| clk_kill_en | input | 1 | Enables the clock interlock |
| reg_kill_en | input | 1 | Enables the regulator interlock |
| warn_hi | output | NUM_CH | Sticky above-upper-limit bits |
| warn_lo | output | NUM_CH | Sticky below-lower-limit bits |
| pkt_flag | output | 1 | Unmasked-warning flag for the packet status word |
| clk_disable | output | 1 | Clock interlock output |
| reg_disable | output | 1 | Regulator interlock output |

## Verification
The hardest state to reach is a single channel holding both warnings. That needs a lower limit programmed above the upper limit, followed by two steps in opposite valid phases with no clear between them. The bench programs that inverted pair directly and drives the two steps back to back. It also drives a clear strobe in the same cycle as a matching step, to show that the set is not lost. A step with a matching counter is also driven during `cycle_start` while the valid flags are high, to confirm that the flags are suppressed on that cycle.

// File: rtl/lmc_pkg.sv
package lmc_pkg;

   // Result of one channel's limit comparison for the current step
   typedef struct packed {
      logic over_hit;
      logic under_hit;
   } lmc_evt_t;

   // Reduction helper used by the action stage
   function automatic logic lmc_any(input logic [63:0] bits, input int n);
      logic r;
      r = 1'b0;
      for (int i = 0; i < 64; i++) begin
         if (i < n) r = r | bits[i];
      end
      return r;
   endfunction

endpackage

// File: rtl/lmc_chan_cmp.sv
module lmc_chan_cmp
   import lmc_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic [CNT_W-1:0] ramp_cnt,
   input  logic             step_en,
   input  logic             vld_eff,
   input  logic [CNT_W-1:0] upper,
   input  logic [CNT_W-1:0] lower,
   output lmc_evt_t         evt
);

   logic eq_up;
   logic eq_lo;

   assign eq_up = (ramp_cnt == upper);
   assign eq_lo = (ramp_cnt == lower);

   // Above-limit: ramp reached the upper limit before the input was crossed
   // Below-limit: input was already crossed when the ramp reached the lower limit
   always_comb begin
      evt.over_hit  = step_en & eq_up & ~vld_eff;
      evt.under_hit = step_en & eq_lo &  vld_eff;
   end

endmodule

// File: rtl/lmc_warn_bank.sv
module lmc_warn_bank #(
   parameter int NUM_CH       = 7,
   parameter bit SET_OVER_CLR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] set_hi,
   input  logic [NUM_CH-1:0] set_lo,
   input  logic              clr_warn,
   output logic [NUM_CH-1:0] warn_hi,
   output logic [NUM_CH-1:0] warn_lo
);

   logic [NUM_CH-1:0] nxt_hi;
   logic [NUM_CH-1:0] nxt_lo;

   generate
      if (SET_OVER_CLR) begin : g_set_wins
         always_comb begin
            nxt_hi = (clr_warn ? '0 : warn_hi) | set_hi;
            nxt_lo = (clr_warn ? '0 : warn_lo) | set_lo;
         end
      end else begin : g_clr_wins
         always_comb begin
            nxt_hi = clr_warn ? '0 : (warn_hi | set_hi);
            nxt_lo = clr_warn ? '0 : (warn_lo | set_lo);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         warn_hi <= '0;
         warn_lo <= '0;
      end else begin
         warn_hi <= nxt_hi;
         warn_lo <= nxt_lo;
      end
   end

   genvar gi;
   generate
      for (gi = 0; gi < NUM_CH; gi++) begin : g_chk
         if (SET_OVER_CLR) begin : g_sc
            AST_CLR_HI: assert property (@(posedge clk) disable iff (!rst_n) (clr_warn && !set_hi[gi]) |=> !warn_hi[gi]); // R5
            AST_CLR_LO: assert property (@(posedge clk) disable iff (!rst_n) (clr_warn && !set_lo[gi]) |=> !warn_lo[gi]); // R5
         end
      end
   endgenerate

endmodule

// File: rtl/lmc_action.sv
module lmc_action
   import lmc_pkg::*;
#(
   parameter int NUM_CH = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] warn_hi,
   input  logic [NUM_CH-1:0] warn_lo,
   input  logic [NUM_CH-1:0] mask,
   input  logic              clk_kill_en,
   input  logic              reg_kill_en,
   output logic              pkt_flag,
   output logic              clk_disable,
   output logic              reg_disable
);

   logic [63:0] live;
   logic        any_live;

   always_comb begin
      live              = '0;
      live[NUM_CH-1:0]  = (warn_hi | warn_lo) & ~mask;
      any_live          = lmc_any(live, NUM_CH);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pkt_flag    <= 1'b0;
         clk_disable <= 1'b0;
         reg_disable <= 1'b0;
      end else begin
         pkt_flag    <= any_live;
         clk_disable <= any_live & clk_kill_en;
         reg_disable <= any_live & reg_kill_en;
      end
   end

   AST_FLAG_TRACK: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> (pkt_flag == $past(|((warn_hi | warn_lo) & ~mask)))); // R7
   AST_CLK_GATED: assert property (@(posedge clk) disable iff (!rst_n) !clk_kill_en |=> !clk_disable); // R8
   AST_REG_GATED: assert property (@(posedge clk) disable iff (!rst_n) !reg_kill_en |=> !reg_disable); // R9
   AST_IL_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (clk_disable || reg_disable) |-> pkt_flag); // R8

endmodule

// File: rtl/lmc_limit_chk.sv
module lmc_limit_chk
   import lmc_pkg::*;
#(
   parameter int NUM_CH       = 7,
   parameter int CNT_W        = 10,
   parameter bit SET_OVER_CLR = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [CNT_W-1:0]        ramp_cnt,
   input  logic                    step_en,
   input  logic                    cycle_start,
   input  logic [NUM_CH-1:0]       valid,
   input  logic [NUM_CH*CNT_W-1:0] hi_lim,
   input  logic [NUM_CH*CNT_W-1:0] lo_lim,
   input  logic [NUM_CH-1:0]       mask,
   input  logic                    clr_warn,
   input  logic                    clk_kill_en,
   input  logic                    reg_kill_en,
   output logic [NUM_CH-1:0]       warn_hi,
   output logic [NUM_CH-1:0]       warn_lo,
   output logic                    pkt_flag,
   output logic                    clk_disable,
   output logic                    reg_disable
);

   localparam int LIM_W = NUM_CH * CNT_W;

   generate
      if (NUM_CH < 1 || NUM_CH > 64) begin : g_bad_ch
         $error("lmc_limit_chk: NUM_CH must be 1..64");
      end
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_w
         $error("lmc_limit_chk: CNT_W must be 2..32");
      end
      if (LIM_W != $bits(hi_lim)) begin : g_bad_lim
         $error("lmc_limit_chk: limit bus width mismatch");
      end
   endgenerate

   logic [NUM_CH-1:0] vld_eff;
   logic [NUM_CH-1:0] set_hi;
   logic [NUM_CH-1:0] set_lo;

   // R6: flags are being reset by the sequencer at ramp start
   assign vld_eff = cycle_start ? '0 : valid;

   genvar ch;
   generate
      for (ch = 0; ch < NUM_CH; ch++) begin : g_ch
         lmc_evt_t evt;

         lmc_chan_cmp #(.CNT_W(CNT_W)) u_cmp (
            .ramp_cnt (ramp_cnt),
            .step_en  (step_en),
            .vld_eff  (vld_eff[ch]),
            .upper    (hi_lim[ch*CNT_W +: CNT_W]),
            .lower    (lo_lim[ch*CNT_W +: CNT_W]),
            .evt      (evt)
         );

         assign set_hi[ch] = evt.over_hit;
         assign set_lo[ch] = evt.under_hit;

         AST_HI_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n) (step_en && ramp_cnt == hi_lim[ch*CNT_W +: CNT_W] && (!valid[ch] || cycle_start)) |=> warn_hi[ch]); // R1
         AST_LO_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n) (step_en && !cycle_start && valid[ch] && ramp_cnt == lo_lim[ch*CNT_W +: CNT_W]) |=> warn_lo[ch]); // R2
         AST_NO_STEP_HI: assert property (@(posedge clk) disable iff (!rst_n) (!step_en && !warn_hi[ch]) |=> !warn_hi[ch]); // R3
         AST_NO_STEP_LO: assert property (@(posedge clk) disable iff (!rst_n) (!step_en && !warn_lo[ch]) |=> !warn_lo[ch]); // R3
         AST_HOLD_HI: assert property (@(posedge clk) disable iff (!rst_n) (warn_hi[ch] && !clr_warn) |=> warn_hi[ch]); // R4
         AST_HOLD_LO: assert property (@(posedge clk) disable iff (!rst_n) (warn_lo[ch] && !clr_warn) |=> warn_lo[ch]); // R4
         AST_START_NO_LO: assert property (@(posedge clk) disable iff (!rst_n) (cycle_start && !warn_lo[ch] && !$isunknown(ramp_cnt)) |=> !warn_lo[ch]); // R6
      end
   endgenerate

   lmc_warn_bank #(
      .NUM_CH       (NUM_CH),
      .SET_OVER_CLR (SET_OVER_CLR)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_hi   (set_hi),
      .set_lo   (set_lo),
      .clr_warn (clr_warn),
      .warn_hi  (warn_hi),
      .warn_lo  (warn_lo)
   );

   lmc_action #(.NUM_CH(NUM_CH)) u_act (
      .clk         (clk),
      .rst_n       (rst_n),
      .warn_hi     (warn_hi),
      .warn_lo     (warn_lo),
      .mask        (mask),
      .clk_kill_en (clk_kill_en),
      .reg_kill_en (reg_kill_en),
      .pkt_flag    (pkt_flag),
      .clk_disable (clk_disable),
      .reg_disable (reg_disable)
   );

endmodule

// File: tb/lmc_limit_chk_tb.sv
module lmc_limit_chk_tb_top;

   localparam int NCH = 7;
   localparam int CW  = 10;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [CW-1:0]   ramp_cnt = '0;
   logic            step_en = 1'b0;
   logic            cycle_start = 1'b0;
   logic [NCH-1:0]  valid = '0;
   logic [NCH*CW-1:0] hi_lim = '0;
   logic [NCH*CW-1:0] lo_lim = '0;
   logic [NCH-1:0]  mask = '0;
   logic            clr_warn = 1'b0;
   logic            clk_kill_en = 1'b0;
   logic            reg_kill_en = 1'b0;
   logic [NCH-1:0]  warn_hi;
   logic [NCH-1:0]  warn_lo;
   logic            pkt_flag;
   logic            clk_disable;
   logic            reg_disable;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   lmc_limit_chk #(.NUM_CH(NCH), .CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .ramp_cnt(ramp_cnt), .step_en(step_en),
      .cycle_start(cycle_start), .valid(valid), .hi_lim(hi_lim), .lo_lim(lo_lim),
      .mask(mask), .clr_warn(clr_warn), .clk_kill_en(clk_kill_en),
      .reg_kill_en(reg_kill_en), .warn_hi(warn_hi), .warn_lo(warn_lo),
      .pkt_flag(pkt_flag), .clk_disable(clk_disable), .reg_disable(reg_disable)
   );

   typedef struct packed {
      logic [CW-1:0]  cnt;
      logic [NCH-1:0] vld;
      logic           st;
      logic [NCH-1:0] ehi;
      logic [NCH-1:0] elo;
   } vec_t;

   // limits: upper = 100 + 10*ch, lower = 40 + 10*ch
   localparam vec_t VEC [9] = '{
      '{10'd100, 7'h00, 1'b0, 7'h01, 7'h00},   // R1 ch0 above
      '{10'd100, 7'h01, 1'b0, 7'h00, 7'h00},   // R3 valid already set
      '{10'd40,  7'h01, 1'b0, 7'h00, 7'h01},   // R2 ch0 below
      '{10'd40,  7'h00, 1'b0, 7'h00, 7'h00},   // R3 valid still clear
      '{10'd120, 7'h7B, 1'b0, 7'h04, 7'h00},   // R1 ch2 above
      '{10'd60,  7'h7F, 1'b1, 7'h00, 7'h00},   // R6 start masks valid
      '{10'd60,  7'h7F, 1'b0, 7'h00, 7'h04},   // R2 ch2 below
      '{10'd160, 7'h00, 1'b0, 7'h40, 7'h00},   // R1 ch6 above
      '{10'd55,  7'h00, 1'b0, 7'h00, 7'h00}    // R3 no match
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_step(input logic [CW-1:0] c, input logic [NCH-1:0] v, input logic s, input logic clr);
      @(negedge clk);
      ramp_cnt = c; valid = v; cycle_start = s; step_en = 1'b1; clr_warn = clr;
      @(negedge clk);
      step_en = 1'b0; cycle_start = 1'b0; clr_warn = 1'b0;
   endtask

   task automatic do_clear();
      @(negedge clk);
      clr_warn = 1'b1;
      @(negedge clk);
      clr_warn = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      for (int ch = 0; ch < NCH; ch++) begin
         hi_lim[ch*CW +: CW] = CW'(100 + 10*ch);
         lo_lim[ch*CW +: CW] = CW'(40 + 10*ch);
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 warn_hi", 32'(warn_hi), 0);
      check("R11 warn_lo", 32'(warn_lo), 0);
      check("R11 flags", {29'd0, pkt_flag, clk_disable, reg_disable}, 0);

      // table walk: each vector starts from a cleared bank
      for (int k = 0; k < 9; k++) begin
         do_clear();
         do_step(VEC[k].cnt, VEC[k].vld, VEC[k].st, 1'b0);
         check($sformatf("R1/R2/R3/R6 vec%0d warn_hi", k), 32'(warn_hi), 32'(VEC[k].ehi));
         check($sformatf("R1/R2/R3/R6 vec%0d warn_lo", k), 32'(warn_lo), 32'(VEC[k].elo));
         @(negedge clk);
         check($sformatf("R7 vec%0d pkt_flag", k), 32'(pkt_flag), 32'(|(VEC[k].ehi | VEC[k].elo)));
      end

      // R3: matching counter without step qualifier
      do_clear();
      @(negedge clk);
      ramp_cnt = 10'd100; valid = '0;
      repeat (2) @(negedge clk);
      check("R3 no step_en", 32'(warn_hi), 0);

      // R4: sticky through ramp restart and non-matching steps
      do_step(10'd100, 7'h00, 1'b0, 1'b0);
      @(negedge clk);
      cycle_start = 1'b1;
      @(negedge clk);
      cycle_start = 1'b0;
      do_step(10'd55, 7'h7F, 1'b0, 1'b0);
      check("R4 sticky hi", 32'(warn_hi), 32'h01);

      // R5: clear and set in same cycle, then clear alone
      do_step(10'd110, 7'h00, 1'b0, 1'b1);
      check("R5 set beats clear", 32'(warn_hi), 32'h02);
      do_clear();
      check("R5 clear", 32'(warn_hi), 0);

      // R7/R8/R9: mask and interlock enables
      @(negedge clk);
      mask = 7'h01; clk_kill_en = 1'b1; reg_kill_en = 1'b1;
      do_step(10'd100, 7'h00, 1'b0, 1'b0);
      @(negedge clk);
      check("R7 masked flag", 32'(pkt_flag), 0);
      check("R8 masked clk", 32'(clk_disable), 0);
      check("R9 masked reg", 32'(reg_disable), 0);
      mask = '0;
      @(negedge clk);
      check("R7 unmasked flag", 32'(pkt_flag), 1);
      check("R8 clk interlock", 32'(clk_disable), 1);
      check("R9 reg interlock", 32'(reg_disable), 1);
      reg_kill_en = 1'b0;
      @(negedge clk);
      check("R9 reg disabled", 32'(reg_disable), 0);
      check("R8 clk independent", 32'(clk_disable), 1);
      clk_kill_en = 1'b0; reg_kill_en = 1'b1;
      @(negedge clk);
      check("R8 clk disabled", 32'(clk_disable), 0);
      check("R9 reg independent", 32'(reg_disable), 1);
      reg_kill_en = 1'b0;

      // R10: inverted limits on ch3 (lower 200 > upper 130)
      lo_lim[3*CW +: CW] = 10'd200;
      do_clear();
      do_step(10'd130, 7'h00, 1'b0, 1'b0);
      do_step(10'd200, 7'h08, 1'b0, 1'b0);
      check("R10 both hi", 32'(warn_hi), 32'h08);
      check("R10 both lo", 32'(warn_lo), 32'h08);

      // R11: reset clears everything
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R11 reset warn", {16'd0, 1'b0, warn_hi, 1'b0, warn_lo}, 0);
      check("R11 reset flag", 32'(pkt_flag), 0);
      rst_n = 1'b1;
      @(negedge clk);
      finish_run();
   end

endmodule